// File: doc/BRIEF.md
# SOF-Driven Oscillator Trim Calibrator

This block tunes a free-running local oscillator without a crystal, using the host's start-of-frame traffic as its timing reference. It watches the decoded line level after each start-of-packet indication and measures how many local clock cycles a few bits of the alternating preamble occupy. When the packet turns out to be a start-of-frame packet, that measurement gives a quick coarse correction to the trim code. From then on the block counts local cycles between successive start-of-frame strobes and compares each count with the nominal frame length. Each in-range result moves the trim code in proportion to the error.

Both stages convert a cycle error into a trim step through one shared scaling. The remainder that is lost when the error is divided down is kept in a register and added to the next correction, so repeated small errors are not thrown away. The coarse error is scaled up by the ratio of frame length to preamble length, so the coarse stage and the fine stage work in the same units. The lock flag reports that the frame counts have settled. If start-of-frame strobes stop arriving, the block drops lock and falls back to the coarse stage.

Top module: `osc_trim_cal`

## Requirements
- R1: After reset, `trim_code` equals TRIM_INIT (128), `locked` is 0, and the block is idle.
- R2: While idle (no `pkt_start` seen since reset), `sof_seen` pulses leave `trim_code` and `locked` unchanged. The first `pkt_start` moves the block to the coarse stage.
- R3: After a `pkt_start`, the coarse measurement is the number of cycles from the first change of `line_lvl` to the SYNC_BITS-th (4th) change after it. For a preamble bit width of w cycles, this is 4*w.
- R4: In the coarse stage, a `sof_seen` with a complete measurement S applies the error e = (S - 32) * 32. Any error is applied as follows: t = e + r, where r is the carried remainder (0..7, reset to 0). `trim_code` decreases by floor(t/8), and r becomes t - 8*floor(t/8). The block then enters the fine stage. `trim_code` changes on the clock edge that samples the strobe.
- R5: In the coarse stage, a `sof_seen` without a complete measurement changes nothing.
- R6: In the fine stage and when locked, the interval is the number of cycles between consecutive `sof_seen` strobes. The error e = interval - 1024 is applied as in R4 when |e| <= 128.
- R7: An interval with |e| > 128 is discarded: `trim_code` and `locked` stay unchanged.
- R8: `locked` rises after two consecutive applied intervals with |e| <= 8. An applied interval with |e| > 8 restarts the count.
- R9: When locked, an applied interval with |e| > 8 clears `locked` and returns the block to the fine stage.
- R10: `trim_code` saturates at 0 and at 255 and never wraps.
- R11: In the fine stage or when locked, 3072 cycles without a `sof_seen` clear `locked`, return the block to the coarse stage, and drop any earlier preamble measurement.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | One-cycle strobe at the start of a received packet |
| line_lvl | input | 1 | Decoded received line level |
| sof_seen | input | 1 | One-cycle strobe when a start-of-frame packet is recognised |
| trim_code | output | 8 | Oscillator trim control word |
| locked | output | 1 | Frame timing has settled |

## Verification
Preamble bit widths from very narrow (2 cycles) to very wide (20 cycles) are tried. These show whether the coarse scaling and sign are right and where the trim saturates at each end. Frame intervals are varied in several ways:
- Small random offsets around nominal exercise the remainder carry and the two-in-a-row lock rule.
- Offsets just outside the tolerance separate a relock from a false lock.
- Offsets beyond the discard bound show that bad strobes are ignored.

Start-of-frame strobes are also sent with no usable preamble, both while idle and after a timeout. These show that stale or missing coarse data is never applied.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  localparam int ERR_W = 18;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COARSE = 2'd1,
    ST_FINE   = 2'd2,
    ST_LOCKED = 2'd3
  } cal_state_t;
endpackage

// File: rtl/sync_bit_meter.sv
module sync_bit_meter #(
  parameter int SYNC_BITS = 4,
  parameter int SUM_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             line_i,
  output logic             done_o,
  output logic [SUM_W-1:0] sum_o
);
  localparam int EC_W = $clog2(SYNC_BITS + 1);
  localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(SYNC_BITS - 1);

  typedef enum logic [1:0] {M_OFF, M_WAIT, M_RUN} meter_t;

  meter_t          phase;
  logic            prev_lvl;
  logic [EC_W-1:0] edges;
  logic            edge_w;

  assign edge_w = line_i ^ prev_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      phase    <= M_OFF;
      edges    <= '0;
      sum_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      prev_lvl <= line_i;
      if (start_i) begin
        phase  <= M_WAIT;
        done_o <= 1'b0;
      end else if (clear_i) begin
        phase  <= M_OFF;
        done_o <= 1'b0;
      end else begin
        case (phase)
          M_WAIT: if (edge_w) begin
            phase <= M_RUN;
            sum_o <= '0;
            edges <= '0;
          end
          M_RUN: begin
            if (&sum_o) begin
              phase <= M_OFF;
            end else begin
              sum_o <= sum_o + 1'b1;
              if (edge_w) begin
                edges <= edges + 1'b1;
                if (edges == LAST_EDGE) begin
                  done_o <= 1'b1;
                  phase  <= M_OFF;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r3_done_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(edge_w));
  a_r3_sum_floor: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (sum_o >= SUM_W'(SYNC_BITS)));
endmodule

// File: rtl/frame_gap_counter.sv
module frame_gap_counter #(
  parameter int CNT_W = 13,
  parameter int LIMIT = 3072
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  always_ff @(posedge clk) begin
    if (rst)             cnt_o <= '0;
    else if (sof_i)      cnt_o <= CNT_W'(1);
    else if (!(&cnt_o))  cnt_o <= cnt_o + 1'b1;
  end

  assign expired_o = (cnt_o >= CNT_W'(LIMIT));

  a_r6_gap_restart: assert property (@(posedge clk) disable iff (rst)
    $past(sof_i) |-> (cnt_o == CNT_W'(1)));
endmodule

// File: rtl/trim_accum.sv
module trim_accum
  import osc_cal_pkg::*;
#(
  parameter int TRIM_W    = 8,
  parameter int TRIM_INIT = 128,
  parameter int GAIN_SH   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    apply_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic [TRIM_W-1:0]       trim_o
);
  localparam logic signed [ERR_W+1:0] TMAX_S = (1 << TRIM_W) - 1;

  logic [GAIN_SH-1:0]      resid;
  logic signed [ERR_W:0]   tot;
  logic signed [ERR_W:0]   quo;
  logic signed [ERR_W+1:0] nxt;
  logic [TRIM_W-1:0]       clamped;

  always_comb begin
    tot = $signed({err_i[ERR_W-1], err_i}) + $signed({{(ERR_W + 1 - GAIN_SH){1'b0}}, resid});
    quo = tot >>> GAIN_SH;
    nxt = $signed({{(ERR_W + 2 - TRIM_W){1'b0}}, trim_o}) - $signed({quo[ERR_W], quo});
    if (nxt < 0)           clamped = '0;
    else if (nxt > TMAX_S) clamped = '1;
    else                   clamped = nxt[TRIM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trim_o <= TRIM_W'(TRIM_INIT);
      resid  <= '0;
    end else if (apply_i) begin
      trim_o <= clamped;
      resid  <= tot[GAIN_SH-1:0];
    end
  end

  a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
    !$past(apply_i) |-> $stable(trim_o));
  a_r4_fast_lowers: assert property (@(posedge clk) disable iff (rst)
    $past(apply_i && (err_i >= ERR_W'(1 << GAIN_SH))) |-> (trim_o <= $past(trim_o)));
endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
  import osc_cal_pkg::*;
#(
  parameter int TRIM_W      = 8,
  parameter int TRIM_INIT   = 128,
  parameter int NOM_BIT     = 8,
  parameter int SYNC_BITS   = 4,
  parameter int NOM_FRAME   = 1024,
  parameter int FRAME_BOUND = 128,
  parameter int LOCK_TOL    = 8,
  parameter int GAIN_SH     = 3,
  parameter int MISS_FRAMES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_start,
  input  logic              line_lvl,
  input  logic              sof_seen,
  output logic [TRIM_W-1:0] trim_code,
  output logic              locked
);
  localparam int SYNC_NOM = SYNC_BITS * NOM_BIT;
  localparam int SUM_W    = $clog2(4 * SYNC_NOM) + 1;
  localparam int SCALE_SH = $clog2(NOM_FRAME / SYNC_NOM);
  localparam int TIMEOUT  = MISS_FRAMES * NOM_FRAME;
  localparam int CNT_W    = $clog2(TIMEOUT + 1) + 1;
  localparam logic signed [ERR_W-1:0] BND_P = FRAME_BOUND;
  localparam logic signed [ERR_W-1:0] BND_N = -FRAME_BOUND;
  localparam logic signed [ERR_W-1:0] TOL_P = LOCK_TOL;
  localparam logic signed [ERR_W-1:0] TOL_N = -LOCK_TOL;

  cal_state_t              state;
  logic                    good_one;
  logic                    sync_done;
  logic [SUM_W-1:0]        sync_sum;
  logic [CNT_W-1:0]        gap_cnt;
  logic                    gap_expired;
  logic signed [ERR_W-1:0] fine_err, coarse_diff, err_sel;
  logic                    in_bound, in_tol, apply, timeout;

  sync_bit_meter #(.SYNC_BITS(SYNC_BITS), .SUM_W(SUM_W)) u_meter (
    .clk(clk), .rst(rst), .start_i(pkt_start), .clear_i(timeout),
    .line_i(line_lvl), .done_o(sync_done), .sum_o(sync_sum)
  );

  frame_gap_counter #(.CNT_W(CNT_W), .LIMIT(TIMEOUT)) u_gap (
    .clk(clk), .rst(rst), .sof_i(sof_seen), .cnt_o(gap_cnt), .expired_o(gap_expired)
  );

  trim_accum #(.TRIM_W(TRIM_W), .TRIM_INIT(TRIM_INIT), .GAIN_SH(GAIN_SH)) u_trim (
    .clk(clk), .rst(rst), .apply_i(apply), .err_i(err_sel), .trim_o(trim_code)
  );

  always_comb begin
    fine_err    = $signed({{(ERR_W - CNT_W){1'b0}}, gap_cnt}) - ERR_W'(NOM_FRAME);
    coarse_diff = $signed({{(ERR_W - SUM_W){1'b0}}, sync_sum}) - ERR_W'(SYNC_NOM);
    in_bound    = (fine_err <= BND_P) && (fine_err >= BND_N);
    in_tol      = (fine_err <= TOL_P) && (fine_err >= TOL_N);
    apply       = 1'b0;
    err_sel     = fine_err;
    timeout     = 1'b0;
    case (state)
      ST_COARSE: if (sof_seen && sync_done) begin
        apply   = 1'b1;
        err_sel = coarse_diff <<< SCALE_SH;
      end
      ST_FINE, ST_LOCKED: begin
        apply   = sof_seen && in_bound;
        timeout = !sof_seen && gap_expired;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      good_one <= 1'b0;
      locked   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:   if (pkt_start) state <= ST_COARSE;
        ST_COARSE: if (apply) begin
          state    <= ST_FINE;
          good_one <= 1'b0;
        end
        ST_FINE: begin
          if (apply) begin
            if (in_tol && good_one) begin
              state  <= ST_LOCKED;
              locked <= 1'b1;
            end
            good_one <= in_tol;
          end else if (timeout) begin
            state    <= ST_COARSE;
            good_one <= 1'b0;
          end
        end
        default: begin
          if ((apply && !in_tol) || timeout) begin
            state    <= timeout ? ST_COARSE : ST_FINE;
            locked   <= 1'b0;
            good_one <= 1'b0;
          end
        end
      endcase
    end
  end

  a_r1_idle_trim: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (trim_code == TRIM_W'(TRIM_INIT) && !locked));
  a_r8_lock_on_sof: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(sof_seen));
  a_r7_discard_hold: assert property (@(posedge clk) disable iff (rst)
    (sof_seen && !in_bound && (state == ST_FINE || state == ST_LOCKED))
      |=> ($stable(trim_code) && $stable(locked)));
  a_r11_timeout_drop: assert property (@(posedge clk) disable iff (rst)
    timeout |=> (!locked && state == ST_COARSE));
endmodule

// File: tb/test_osc_trim_cal.sv
module test_osc_trim_cal;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pkt_start = 1'b0;
  logic line_lvl = 1'b1;
  logic sof_seen = 1'b0;
  logic [7:0] trim_code;
  logic locked;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int exp_trim = 128;
  int resid = 0;
  int st = 0;
  int good = 0;
  int exp_lk = 0;

  always #5 clk = ~clk;

  osc_trim_cal i_osc_trim_cal (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .line_lvl(line_lvl),
    .sof_seen(sof_seen), .trim_code(trim_code), .locked(locked)
  );

  function automatic int fdiv8(input int t);
    if (t >= 0) return t / 8;
    return -((-t + 7) / 8);
  endfunction

  task automatic apply_err(input int e);
    int t, q;
    t = e + resid;
    q = fdiv8(t);
    resid = t - q * 8;
    exp_trim = exp_trim - q;
    if (exp_trim < 0) exp_trim = 0;
    if (exp_trim > 255) exp_trim = 255;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sof_pulse();
    sof_seen = 1'b1;
    tick();
    sof_seen = 1'b0;
  endtask

  task automatic send_sync(input int w);
    pkt_start = 1'b1;
    tick();
    pkt_start = 1'b0;
    tick();
    for (int k = 0; k < 6; k++) begin
      line_lvl = ~line_lvl;
      repeat (w) tick();
    end
    repeat (3) tick();
  endtask

  task automatic coarse(input int w, input string tag);
    send_sync(w);
    sof_pulse();
    apply_err((4 * w - 32) * 32);
    st = 2;
    good = 0;
    check({tag, " trim"}, trim_code, exp_trim);
  endtask

  task automatic frame(input int p, input string tag);
    int e;
    repeat (p - 1) tick();
    sof_pulse();
    e = p - 1024;
    if (e >= -128 && e <= 128) begin
      apply_err(e);
      if (e >= -8 && e <= 8) begin
        if (st == 2) begin
          if (good == 1) begin st = 3; exp_lk = 1; end
          good = 1;
        end
      end else begin
        good = 0;
        if (st == 3) begin st = 2; exp_lk = 0; end
      end
    end
    check({tag, " trim"}, trim_code, exp_trim);
    check({tag, " locked"}, locked, exp_lk);
  endtask

  task automatic go_timeout();
    repeat (3100) tick();
    st = 1; good = 0; exp_lk = 0;
    check("R11 locked after silence", locked, 0);
    sof_pulse();
    check("R11 stale preamble unused", trim_code, exp_trim);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) tick();
    rst = 1'b0;
    tick();
    check("R1 trim", trim_code, 128);
    check("R1 locked", locked, 0);

    sof_pulse();
    repeat (3) tick();
    check("R2 idle trim", trim_code, 128);
    check("R2 idle locked", locked, 0);

    pkt_start = 1'b1; tick(); pkt_start = 1'b0;
    st = 1;
    repeat (20) tick();
    sof_pulse();
    check("R5 no measurement", trim_code, 128);

    coarse(6 + int'($urandom_range(0, 4)), "R3 R4 coarse");

    for (int i = 0; i < 3; i++)
      frame(1024 + int'($urandom_range(0, 12)) - 6, "R6 R8 settle");
    check("R8 locked after two", locked, 1);

    frame(1024 + 200, "R7 discard late");
    frame(1024 - 150, "R7 discard early");
    frame(1024 + 40, "R9 drift unlock");
    check("R9 unlocked", locked, 0);
    frame(1024 - 3, "R8 first good");
    frame(1024 + 60, "R8 restart");
    frame(1024 + 2, "R8 one after restart");
    check("R8 not yet", locked, 0);
    frame(1024 + 1, "R8 relock");
    check("R8 relocked", locked, 1);

    for (int i = 0; i < 8; i++)
      frame(1024 + int'($urandom_range(0, 40)) - 20, "R6 R8 R9 random");

    go_timeout();
    coarse(20, "R10 low saturation");
    check("R10 floor", trim_code, 0);
    frame(1024 - 100, "R6 after coarse");

    go_timeout();
    coarse(2, "R4 narrow bits");
    go_timeout();
    coarse(2, "R4 narrow bits again");
    go_timeout();
    coarse(2, "R10 high saturation");
    check("R10 ceiling", trim_code, 255);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule